// File: doc/BRIEF.md
# Pending Interrupt Priority Arbiter

This block looks at every interrupt source of a controller in a single cycle and names the one that should be taken next. Each exception number owns two slots, a secure one and a non-secure one. Every slot has its own enable, pending flag, fixed-priority flag and 8-bit priority. A slot takes part in the contest only when it is both enabled and pending.

An ordinary priority is cut in two at a programmable binary point. The upper bits form the group priority and the lower bits form the subpriority. Secure slots use one binary point and non-secure slots use another. Slots flagged as fixed carry a negative group priority and always beat ordinary ones. The winner's exception number, its bank and its group priority are registered once per clock, together with a valid flag. When nothing is eligible, the block reports a reserved "no exception" priority.

Top module: `pend_prio_arbiter`

## Requirements
- R1: Slot k stands for exception number k/2. Bit k[0] set marks the secure bank. The slot's priority sits at `src_prio[k*8 +: 8]`. A slot can win only when its `src_en` and `src_pend` bits are both 1.
- R2: Among eligible slots, the lowest group priority wins. For an ordinary slot, the group priority is the priority with bits [bp:0] cleared. Secure slots take bp from `bp_sec` and non-secure slots take it from `bp_nsec`. A bp of 7 makes every ordinary group priority 0.
- R3: When group priorities are equal and not negative, the slot with the lower subpriority wins. The subpriority is the priority's bits [bp:0], using the bp of that slot's own bank.
- R4: When group priority and subpriority are both equal, the lower exception number wins.
- R5: At the same exception number, with everything else equal, the secure slot wins over the non-secure slot.
- R6: A slot with `src_fix` set has group priority -(prio[1:0]+1), a value from -1 to -4. Among equal negative group priorities the subpriority is ignored, and only exception number and bank decide.
- R7: Exception number 0 (slots 0 and 1) never wins, even when it is eligible.
- R8: When no slot is eligible, `win_valid` is 0, `win_idx` is 0, `win_secure` is 0 and `win_grp` is 256.
- R9: The outputs are registered. They show the inputs present at the previous rising edge. Synchronous reset puts them in the R8 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_sec | input | 3 | Binary point for secure slots |
| bp_nsec | input | 3 | Binary point for non-secure slots |
| src_en | input | 2*NUM_IDX | Enable bit per slot |
| src_pend | input | 2*NUM_IDX | Pending bit per slot |
| src_fix | input | 2*NUM_IDX | Fixed negative priority flag per slot |
| src_prio | input | 2*NUM_IDX*8 | Priority per slot, slot k at bits [k*8 +: 8] |
| win_valid | output | 1 | A winner exists |
| win_idx | output | clog2(NUM_IDX) | Winning exception number |
| win_secure | output | 1 | Winner is the secure slot |
| win_grp | output | 10 | Winner's group priority, two's complement; 256 when idle |

## Verification
Subpriority tie-breaking and the exemption for fixed priorities can both come into play on the same cycle. To provoke this, two fixed slots are given the same negative group priority, and the slot with the higher exception number is given the smaller raw low bits. The check expects the lower exception number to win. A second case combines bank-specific binary points with a same-number pair, so that the bank split, the subpriority rule and the secure-first rule all act on one decision. Random trials then draw priorities from a small set, which makes ties common, and each registered result is compared with an ordered reference scan.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int PRIO_W = 8;
    localparam int BP_W   = $clog2(PRIO_W);
    localparam int GP_W   = PRIO_W + 2;

    typedef logic [PRIO_W-1:0]      prio_t;
    typedef logic [BP_W-1:0]        bp_t;
    typedef logic signed [GP_W-1:0] grp_t;

    // reserved idle value, above every legal group priority
    localparam grp_t NOEXC = grp_t'(1 << PRIO_W);

    typedef struct packed {
        logic  elig;
        grp_t  grp;
        prio_t sub;
    } cand_t;

    // bits [bp:0] set
    function automatic prio_t sub_mask(input bp_t bp);
        logic [PRIO_W:0] m;
        m = (PRIO_W+1)'(1) << (int'(bp) + 1);
        return prio_t'(m - (PRIO_W+1)'(1));
    endfunction

    function automatic grp_t fixed_grp(input prio_t p);
        return grp_t'(-(int'(p[1:0]) + 1));
    endfunction

    // strict precedence: a beats b
    function automatic logic beats(input cand_t a, input cand_t b);
        logic lt, eq;
        lt = $signed(a.grp) < $signed(b.grp);
        eq = (a.grp == b.grp);
        return a.elig && (lt || (eq && !a.grp[GP_W-1] && (a.sub < b.sub)));
    endfunction

endpackage

// File: rtl/arb_slot_decode.sv
module arb_slot_decode
    import arb_pkg::*;
#(
    parameter bit BLOCKED = 1'b0
) (
    input  logic  en,
    input  logic  pend,
    input  logic  fix,
    input  prio_t prio,
    input  bp_t   bp,
    output cand_t cand
);

    prio_t mask;

    always_comb begin
        mask      = sub_mask(bp);
        cand.elig = en & pend & !BLOCKED;
        cand.sub  = prio & mask;
        if (fix) cand.grp = fixed_grp(prio);
        else     cand.grp = grp_t'({2'b00, prio & ~mask});
    end

endmodule

// File: rtl/arb_scan.sv
module arb_scan
    import arb_pkg::*;
#(
    parameter int NUM_IDX = 16
) (
    input  cand_t [2*NUM_IDX-1:0]           cands,
    output logic                            win_valid,
    output logic [$clog2(2*NUM_IDX)-1:0]    win_slot,
    output grp_t                            win_grp
);

    localparam int NUM_SLOT = 2 * NUM_IDX;
    localparam int SLOT_W   = $clog2(NUM_SLOT);

    // scan order: ascending number, secure slot before non-secure
    always_comb begin
        cand_t best;
        best     = '{elig: 1'b0, grp: NOEXC, sub: '0};
        win_slot = '0;
        for (int i = 0; i < NUM_IDX; i++) begin
            for (int b = 1; b >= 0; b--) begin
                if (beats(cands[2*i+b], best)) begin
                    best     = cands[2*i+b];
                    win_slot = SLOT_W'(2*i + b);
                end
            end
        end
        win_valid = best.elig;
        win_grp   = best.grp;
    end

    always_comb begin
        if (win_valid) begin
            // R1
            win_elig_chk: assert (cands[win_slot].elig);
        end
    end

endmodule

// File: rtl/pend_prio_arbiter.sv
module pend_prio_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_IDX = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [BP_W-1:0]                   bp_sec,
    input  logic [BP_W-1:0]                   bp_nsec,
    input  logic [2*NUM_IDX-1:0]              src_en,
    input  logic [2*NUM_IDX-1:0]              src_pend,
    input  logic [2*NUM_IDX-1:0]              src_fix,
    input  logic [2*NUM_IDX*PRIO_W-1:0]       src_prio,
    output logic                              win_valid,
    output logic [$clog2(NUM_IDX)-1:0]        win_idx,
    output logic                              win_secure,
    output logic [GP_W-1:0]                   win_grp
);

    localparam int NUM_SLOT = 2 * NUM_IDX;
    localparam int SLOT_W   = $clog2(NUM_SLOT);
    localparam logic [NUM_SLOT-1:0] KEEP = {{(NUM_SLOT-2){1'b1}}, 2'b00};

    cand_t [NUM_SLOT-1:0] cands;
    logic                 nxt_valid;
    logic [SLOT_W-1:0]    nxt_slot;
    grp_t                 nxt_grp;

    for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
        arb_slot_decode #(
            .BLOCKED (k < 2)
        ) u_dec (
            .en   (src_en[k]),
            .pend (src_pend[k]),
            .fix  (src_fix[k]),
            .prio (src_prio[k*PRIO_W +: PRIO_W]),
            .bp   ((k % 2 == 1) ? bp_sec : bp_nsec),
            .cand (cands[k])
        );
    end

    arb_scan #(
        .NUM_IDX (NUM_IDX)
    ) u_scan (
        .cands     (cands),
        .win_valid (nxt_valid),
        .win_slot  (nxt_slot),
        .win_grp   (nxt_grp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_valid  <= 1'b0;
            win_idx    <= '0;
            win_secure <= 1'b0;
            win_grp    <= NOEXC;
        end else begin
            win_valid  <= nxt_valid;
            win_idx    <= nxt_slot[SLOT_W-1:1];
            win_secure <= nxt_slot[0];
            win_grp    <= nxt_grp;
        end
    end

    logic any_elig;
    assign any_elig = |(src_en & src_pend & KEEP);

    // R1
    elig_wins_chk: assert property (@(posedge clk) disable iff (rst)
        any_elig |=> win_valid);

    // R8
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !any_elig |=> (!win_valid && win_grp == NOEXC && win_idx == '0 && !win_secure));

    // R7
    idx_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> win_idx != '0);

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!win_valid && win_grp == NOEXC));

endmodule

// File: tb/tb_pend_prio_arbiter.sv
`timescale 1ns/1ps
module tb_pend_prio_arbiter;

    localparam int NI = 16;
    localparam int NS = 2 * NI;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      bps = '0, bpn = '0;
    logic [NS-1:0]   en = '0, pend = '0, fix = '0;
    logic [NS*8-1:0] prio = '0;
    logic            win_valid;
    logic [3:0]      win_idx;
    logic            win_secure;
    logic [9:0]      win_grp;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pend_prio_arbiter #(.NUM_IDX(NI)) dut (
        .clk(clk), .rst(rst), .bp_sec(bps), .bp_nsec(bpn),
        .src_en(en), .src_pend(pend), .src_fix(fix), .src_prio(prio),
        .win_valid(win_valid), .win_idx(win_idx), .win_secure(win_secure),
        .win_grp(win_grp)
    );

    task automatic check(input string req, input bit v, input int idx,
                         input bit sec, input int grp);
        int got_grp;
        got_grp = int'($signed(win_grp));
        n_chk++;
        if (win_valid !== v || int'(win_idx) != idx || win_secure !== sec || got_grp != grp) begin
            n_fail++;
            $display("FAIL %s: got v=%0b idx=%0d sec=%0b grp=%0d, expected v=%0b idx=%0d sec=%0b grp=%0d",
                     req, win_valid, win_idx, win_secure, got_grp, v, idx, sec, grp);
        end
    endtask

    task automatic clear_all();
        en = '0; pend = '0; fix = '0; prio = '0;
    endtask

    task automatic set_slot(input int k, input bit f, input logic [7:0] p);
        en[k] = 1'b1; pend[k] = 1'b1; fix[k] = f; prio[k*8 +: 8] = p;
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic ref_model(output bit v, output int idx, output bit sec, output int grp);
        int best, bsub, g, s, k, bp, m;
        best = 256; bsub = 0; v = 0; idx = 0; sec = 0;
        for (int i = 1; i < NI; i++) begin
            for (int b = 1; b >= 0; b--) begin
                k  = 2*i + b;
                bp = b ? int'(bps) : int'(bpn);
                m  = (2 << bp) - 1;
                s  = int'(prio[k*8 +: 8]) & m;
                if (fix[k]) g = -(int'(prio[k*8 +: 2]) + 1);
                else        g = int'(prio[k*8 +: 8]) & ~m & 255;
                if (en[k] && pend[k] && (g < best || (g == best && g >= 0 && s < bsub))) begin
                    best = g; bsub = s; v = 1; idx = i; sec = b[0];
                end
            end
        end
        grp = best;
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1; clear_all(); set_slot(5, 0, 8'h10);
        settle();
        check("R9 reset", 0, 0, 0, 256);
        @(negedge clk); rst = 1'b0; clear_all();
        settle();
        check("R8 idle", 0, 0, 0, 256);
    endtask

    task automatic t_elig();
        @(negedge clk); clear_all(); bps = 0; bpn = 0;
        set_slot(6, 0, 8'h00); pend[6] = 1'b0;
        set_slot(9, 0, 8'h00); en[9] = 1'b0;
        set_slot(11, 0, 8'h80);
        settle();
        check("R1 enable and pending", 1, 5, 1, 128);
        @(negedge clk); en[11] = 1'b0;
        settle();
        check("R8 none eligible", 0, 0, 0, 256);
    endtask

    task automatic t_group();
        @(negedge clk); clear_all(); bps = 3; bpn = 3;
        set_slot(4, 0, 8'h40); set_slot(21, 0, 8'h30);
        settle();
        check("R2 lowest group", 1, 10, 1, 48);
        @(negedge clk); clear_all(); bps = 7; bpn = 0;
        set_slot(3, 0, 8'hF0); set_slot(2, 0, 8'h02);
        settle();
        check("R2 bank binary point", 1, 1, 1, 0);
    endtask

    task automatic t_sub();
        @(negedge clk); clear_all(); bps = 3; bpn = 3;
        set_slot(10, 0, 8'h25); set_slot(7, 0, 8'h27);
        settle();
        check("R3 subpriority", 1, 5, 0, 32);
        @(negedge clk); clear_all(); bps = 5; bpn = 1;
        set_slot(3, 0, 8'h3F); set_slot(2, 0, 8'h02);
        settle();
        check("R3 bank split then sub", 1, 1, 0, 0);
    endtask

    task automatic t_index();
        @(negedge clk); clear_all(); bps = 3; bpn = 3;
        set_slot(14, 0, 8'h50); set_slot(25, 0, 8'h50);
        settle();
        check("R4 lower number", 1, 7, 0, 80);
    endtask

    task automatic t_bank();
        @(negedge clk); clear_all(); bps = 3; bpn = 3;
        set_slot(12, 0, 8'h10); set_slot(13, 0, 8'h10);
        settle();
        check("R5 secure first", 1, 6, 1, 16);
    endtask

    task automatic t_fixed();
        @(negedge clk); clear_all(); bps = 3; bpn = 3;
        set_slot(30, 1, 8'h01); set_slot(5, 1, 8'h05); set_slot(3, 0, 8'h00);
        settle();
        check("R6 fixed no subpriority", 1, 2, 1, -2);
        @(negedge clk); set_slot(20, 1, 8'h03);
        settle();
        check("R6 most negative", 1, 10, 0, -4);
    endtask

    task automatic t_zero();
        @(negedge clk); clear_all(); bps = 3; bpn = 3;
        set_slot(0, 1, 8'h00); set_slot(1, 0, 8'h00); set_slot(2, 0, 8'hFF);
        settle();
        check("R7 number 0 skipped", 1, 1, 0, 240);
        @(negedge clk); en[2] = 1'b0;
        settle();
        check("R7 only number 0", 0, 0, 0, 256);
    endtask

    task automatic t_latency();
        @(negedge clk); clear_all(); bps = 3; bpn = 3;
        set_slot(12, 0, 8'h10);
        settle();
        check("R9 first value", 1, 6, 0, 16);
        @(negedge clk); clear_all(); set_slot(21, 0, 8'h30);
        #1;
        check("R9 holds before edge", 1, 6, 0, 16);
        settle();
        check("R9 after edge", 1, 10, 1, 48);
    endtask

    task automatic t_random();
        bit v, s; int idx, g;
        for (int it = 0; it < 300; it++) begin
            @(negedge clk);
            bps = 3'($urandom % 8); bpn = 3'($urandom % 8);
            for (int k = 0; k < NS; k++) begin
                en[k]   = ($urandom % 3) != 0;
                pend[k] = ($urandom % 3) == 0;
                fix[k]  = ($urandom % 10) == 0;
                prio[k*8 +: 8] = 8'((($urandom % 4) << 5) | ($urandom % 4));
            end
            ref_model(v, idx, s, g);
            settle();
            check("R2/R3/R4/R5/R6 random", v, idx, s, g);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_elig();
        t_group();
        t_sub();
        t_index();
        t_bank();
        t_fixed();
        t_zero();
        t_latency();
        t_random();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule